// File: doc/BRIEF.md
# Complex Fixed-Point Multiplier

This block multiplies two complex fixed-point operands, x = xr + j·xi and y = yr + j·yi, and returns the product in fixed point. The number of real multipliers is set when the block is built. One form uses four multipliers: it forms the four cross products and then combines them in one add stage. The other form uses three multipliers: pre-adders come before the multipliers and post-adders come after them. The three-multiplier form saves a multiplier at the cost of extra adders and extra latency.

The multiply stage and each add stage are followed by their own pipeline registers, and the two register depths are set by separate parameters. The block derives its total latency from these depths and reports it on a constant output. The adders either grow by one bit, so the result is always exact, or wrap at the width of their widest operand. Both result components are trimmed to the same number of fractional bits with the same rounding rule. A valid flag is delayed by the total latency so that it lines up with the data.

Top module: `cplx_mul`

## Requirements
- R1: With FOUR_MUL=1 the result before trimming is re = xr·yr − xi·yi and im = xr·yi + xi·yr.
- R2: With FOUR_MUL=0 the block computes k1 = yr·(xr+xi), k2 = xr·(yi−yr) and k3 = xi·(yr+yi), and the result before trimming is re = k1 − k3 and im = k1 + k2.
- R3: The latency in cycles is MUL_PIPE + ADD_PIPE for the four-multiplier form and MUL_PIPE + 2·ADD_PIPE for the three-multiplier form. lat_o carries this value as an 8-bit unsigned number.
- R4: valid_o equals valid_i delayed by exactly the latency. While rst_ni is low, every pipeline register is cleared, so a pipelined build drives valid_o = 0 and zero data.
- R5: Let SH = 2·IN_FRAC − OUT_FRAC. Both components are trimmed by dropping SH fraction bits. With RND=RND_FLOOR this is an arithmetic shift right by SH. With RND=RND_HALF_UP, 2^(SH−1) is added before the shift.
- R6: With OVF=OVF_GROW, every pre-add result is IN_W+1 bits wide and every post-add result is one bit wider than its product, so the result equals the exact value. When xi = yi = 0, im_o is 0.
- R7: With OVF=OVF_WRAP, each pre-add result keeps only the low IN_W bits as a signed value, and each post-add result keeps only the low 2·IN_W bits as a signed value. The kept value is then sign-extended before trimming.
- R8: The output width is OUT_W = 2·IN_W + 2 − SH, two's complement. The data path advances every cycle whatever the state of valid_i. A valid output is never unknown.
- R9: All-zero operands give re_o = im_o = 0 after the latency, in every build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input sample qualifier |
| xr_i | input | IN_W | Real part of x, signed, IN_FRAC fraction bits |
| xi_i | input | IN_W | Imaginary part of x, signed |
| yr_i | input | IN_W | Real part of y, signed |
| yi_i | input | IN_W | Imaginary part of y, signed |
| valid_o | output | 1 | valid_i delayed by the latency |
| re_o | output | OUT_W | Real part of the product, OUT_FRAC fraction bits |
| im_o | output | OUT_W | Imaginary part of the product, OUT_FRAC fraction bits |
| lat_o | output | 8 | Total latency in cycles (constant) |

## Verification
Two things can happen in the same cycle: rounding acting on a value that an adder has just grown or wrapped, and the valid flag reaching the output on the same edge as data that has passed through pipeline stages of different depths. The bench builds three instances, one each of three-multiplier/grow/half-up, four-multiplier/grow/floor and three-multiplier/wrap/floor, each with a different latency. All three receive the same stream of random operands with random valid bits, with corner operands mixed in (the most negative and most positive values, zero and ±1) so that the pre-adders wrap and the rounding carries. Every cycle, each instance's data and valid flag are compared with a bench model taken from the input history at that instance's own latency.

// File: rtl/cm_pkg.sv
package cm_pkg;
  typedef enum logic {OVF_WRAP, OVF_GROW} cm_ovf_e;
  typedef enum logic {RND_FLOOR, RND_HALF_UP} cm_rnd_e;

  function automatic int cm_latency(input bit four_mul, input int mul_pipe, input int add_pipe);
    return four_mul ? (mul_pipe + add_pipe) : (mul_pipe + 2 * add_pipe);
  endfunction
endpackage

// File: rtl/cm_pipe.sv
module cm_pipe #(
  parameter int W = 1,
  parameter int D = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  if (D == 0) begin : g_wire
    assign q_o = d_i;
  end else begin : g_reg
    logic [W-1:0] stg_q [D];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < D; i++) stg_q[i] <= '0;
      end else begin
        stg_q[0] <= d_i;
        for (int i = 1; i < D; i++) stg_q[i] <= stg_q[i-1];
      end
    end
    assign q_o = stg_q[D-1];
  end
endmodule

// File: rtl/cm_core.sv
module cm_core #(
  parameter int  IN_W     = 16,
  parameter bit  FOUR_MUL = 1'b0,
  parameter bit  GROW     = 1'b1,
  parameter int  MUL_PIPE = 0,
  parameter int  ADD_PIPE = 0,
  localparam int SUM_W    = 2 * IN_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [IN_W-1:0]  xr_i,
  input  logic signed [IN_W-1:0]  xi_i,
  input  logic signed [IN_W-1:0]  yr_i,
  input  logic signed [IN_W-1:0]  yi_i,
  output logic signed [SUM_W-1:0] re_o,
  output logic signed [SUM_W-1:0] im_o
);
  logic signed [SUM_W-1:0] re_w, im_w;

  if (FOUR_MUL) begin : g_four
    localparam int PW = 2 * IN_W;
    localparam int AW = GROW ? PW + 1 : PW;
    logic signed [PW-1:0] p_ac, p_bd, p_ad, p_bc, q_ac, q_bd, q_ad, q_bc;
    logic signed [AW-1:0] re_s, im_s;
    assign p_ac = PW'(xr_i) * PW'(yr_i);
    assign p_bd = PW'(xi_i) * PW'(yi_i);
    assign p_ad = PW'(xr_i) * PW'(yi_i);
    assign p_bc = PW'(xi_i) * PW'(yr_i);
    cm_pipe #(.W(PW), .D(MUL_PIPE)) i_m0 (.clk_i, .rst_ni, .d_i(p_ac), .q_o(q_ac));
    cm_pipe #(.W(PW), .D(MUL_PIPE)) i_m1 (.clk_i, .rst_ni, .d_i(p_bd), .q_o(q_bd));
    cm_pipe #(.W(PW), .D(MUL_PIPE)) i_m2 (.clk_i, .rst_ni, .d_i(p_ad), .q_o(q_ad));
    cm_pipe #(.W(PW), .D(MUL_PIPE)) i_m3 (.clk_i, .rst_ni, .d_i(p_bc), .q_o(q_bc));
    assign re_s = AW'(q_ac) - AW'(q_bd);
    assign im_s = AW'(q_ad) + AW'(q_bc);
    assign re_w = SUM_W'(re_s);
    assign im_w = SUM_W'(im_s);
  end else begin : g_three
    localparam int PA_W = GROW ? IN_W + 1 : IN_W;
    localparam int PW   = IN_W + PA_W;
    localparam int AW   = GROW ? PW + 1 : PW;
    logic signed [PA_W-1:0] s1, s2, s3, s1_q, s2_q, s3_q;
    logic signed [IN_W-1:0] xr_q, xi_q, yr_q;
    logic signed [PW-1:0]   k1, k2, k3, k1_q, k2_q, k3_q;
    logic signed [AW-1:0]   re_s, im_s;
    // pre-adders, wrapped or grown by PA_W
    assign s1 = PA_W'(xr_i) + PA_W'(xi_i);
    assign s2 = PA_W'(yi_i) - PA_W'(yr_i);
    assign s3 = PA_W'(yr_i) + PA_W'(yi_i);
    cm_pipe #(.W(PA_W), .D(ADD_PIPE)) i_p0 (.clk_i, .rst_ni, .d_i(s1),   .q_o(s1_q));
    cm_pipe #(.W(PA_W), .D(ADD_PIPE)) i_p1 (.clk_i, .rst_ni, .d_i(s2),   .q_o(s2_q));
    cm_pipe #(.W(PA_W), .D(ADD_PIPE)) i_p2 (.clk_i, .rst_ni, .d_i(s3),   .q_o(s3_q));
    cm_pipe #(.W(IN_W), .D(ADD_PIPE)) i_p3 (.clk_i, .rst_ni, .d_i(xr_i), .q_o(xr_q));
    cm_pipe #(.W(IN_W), .D(ADD_PIPE)) i_p4 (.clk_i, .rst_ni, .d_i(xi_i), .q_o(xi_q));
    cm_pipe #(.W(IN_W), .D(ADD_PIPE)) i_p5 (.clk_i, .rst_ni, .d_i(yr_i), .q_o(yr_q));
    assign k1 = PW'(yr_q) * PW'(s1_q);
    assign k2 = PW'(xr_q) * PW'(s2_q);
    assign k3 = PW'(xi_q) * PW'(s3_q);
    cm_pipe #(.W(PW), .D(MUL_PIPE)) i_m0 (.clk_i, .rst_ni, .d_i(k1), .q_o(k1_q));
    cm_pipe #(.W(PW), .D(MUL_PIPE)) i_m1 (.clk_i, .rst_ni, .d_i(k2), .q_o(k2_q));
    cm_pipe #(.W(PW), .D(MUL_PIPE)) i_m2 (.clk_i, .rst_ni, .d_i(k3), .q_o(k3_q));
    assign re_s = AW'(k1_q) - AW'(k3_q);
    assign im_s = AW'(k1_q) + AW'(k2_q);
    assign re_w = SUM_W'(re_s);
    assign im_w = SUM_W'(im_s);
  end

  // post-add pipeline, common to both forms
  cm_pipe #(.W(SUM_W), .D(ADD_PIPE)) i_a0 (.clk_i, .rst_ni, .d_i(re_w), .q_o(re_o));
  cm_pipe #(.W(SUM_W), .D(ADD_PIPE)) i_a1 (.clk_i, .rst_ni, .d_i(im_w), .q_o(im_o));
endmodule

// File: rtl/cm_trim.sv
module cm_trim #(
  parameter int             SUM_W = 34,
  parameter int             SH    = 14,
  parameter cm_pkg::cm_rnd_e RND  = cm_pkg::RND_HALF_UP,
  localparam int            OW    = SUM_W - SH
) (
  input  logic signed [SUM_W-1:0] v_i,
  output logic signed [OW-1:0]    v_o
);
  if (SH == 0) begin : g_pass
    assign v_o = v_i;
  end else if (RND == cm_pkg::RND_HALF_UP) begin : g_half
    logic [SUM_W-1:0] biased;
    assign biased = v_i + (SUM_W'(1) << (SH - 1));
    assign v_o    = biased[SUM_W-1:SH];
  end else begin : g_floor
    assign v_o = v_i[SUM_W-1:SH];
  end
endmodule

// File: rtl/cplx_mul.sv
module cplx_mul #(
  parameter int              IN_W     = 16,
  parameter int              IN_FRAC  = 14,
  parameter int              OUT_FRAC = 14,
  parameter bit              FOUR_MUL = 1'b0,
  parameter cm_pkg::cm_ovf_e OVF      = cm_pkg::OVF_GROW,
  parameter cm_pkg::cm_rnd_e RND      = cm_pkg::RND_HALF_UP,
  parameter int              MUL_PIPE = 0,
  parameter int              ADD_PIPE = 0,
  localparam int             SUM_W    = 2 * IN_W + 2,
  localparam int             SH       = 2 * IN_FRAC - OUT_FRAC,
  localparam int             OUT_W    = SUM_W - SH,
  localparam int             LAT      = cm_pkg::cm_latency(FOUR_MUL, MUL_PIPE, ADD_PIPE)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic signed [IN_W-1:0]  xr_i,
  input  logic signed [IN_W-1:0]  xi_i,
  input  logic signed [IN_W-1:0]  yr_i,
  input  logic signed [IN_W-1:0]  yi_i,
  output logic                    valid_o,
  output logic signed [OUT_W-1:0] re_o,
  output logic signed [OUT_W-1:0] im_o,
  output logic [7:0]              lat_o
);
  logic signed [SUM_W-1:0] re_full, im_full;

  cm_core #(
    .IN_W(IN_W), .FOUR_MUL(FOUR_MUL), .GROW(OVF == cm_pkg::OVF_GROW),
    .MUL_PIPE(MUL_PIPE), .ADD_PIPE(ADD_PIPE)
  ) i_core (
    .clk_i, .rst_ni, .xr_i, .xi_i, .yr_i, .yi_i, .re_o(re_full), .im_o(im_full)
  );

  cm_trim #(.SUM_W(SUM_W), .SH(SH), .RND(RND)) i_trim_re (.v_i(re_full), .v_o(re_o));
  cm_trim #(.SUM_W(SUM_W), .SH(SH), .RND(RND)) i_trim_im (.v_i(im_full), .v_o(im_o));

  cm_pipe #(.W(1), .D(LAT)) i_vld (.clk_i, .rst_ni, .d_i(valid_i), .q_o(valid_o));

  assign lat_o = 8'(LAT);
endmodule

// File: rtl/cm_chk.sv
module cm_chk #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 20,
  parameter int LAT   = 0,
  parameter bit GROW  = 1'b1
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    valid_i,
  input logic signed [IN_W-1:0]  xr_i,
  input logic signed [IN_W-1:0]  xi_i,
  input logic signed [IN_W-1:0]  yr_i,
  input logic signed [IN_W-1:0]  yi_i,
  input logic                    valid_o,
  input logic signed [OUT_W-1:0] re_o,
  input logic signed [OUT_W-1:0] im_o
);
  logic [LAT:0] vld_sh, zero_sh, real_sh;
  assign vld_sh[0]  = valid_i;
  assign zero_sh[0] = (xr_i == '0) && (xi_i == '0) && (yr_i == '0) && (yi_i == '0);
  assign real_sh[0] = (xi_i == '0) && (yi_i == '0);

  for (genvar i = 1; i <= LAT; i++) begin : g_sh
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_sh[i]  <= 1'b0;
        zero_sh[i] <= 1'b0;
        real_sh[i] <= 1'b0;
      end else begin
        vld_sh[i]  <= vld_sh[i-1];
        zero_sh[i] <= zero_sh[i-1];
        real_sh[i] <= real_sh[i-1];
      end
    end
  end

  AST_VALID_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vld_sh[LAT]); // R4

  AST_ZERO_PRODUCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_sh[LAT] |-> (re_o == '0) && (im_o == '0)); // R9

  AST_OUT_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !$isunknown({re_o, im_o})); // R8

  if (GROW) begin : g_grow
    AST_REAL_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      real_sh[LAT] |-> (im_o == '0)); // R6
  end

  if (LAT > 0) begin : g_rst
    always_comb begin
      if (rst_ni == 1'b0) begin
        AST_RESET_QUIET: assert (valid_o == 1'b0); // R4
      end
    end
  end
endmodule

bind cplx_mul cm_chk #(
  .IN_W(IN_W), .OUT_W(OUT_W), .LAT(LAT), .GROW(OVF == cm_pkg::OVF_GROW)
) i_cm_chk (
  .clk_i, .rst_ni, .valid_i, .xr_i, .xi_i, .yr_i, .yi_i, .valid_o, .re_o, .im_o
);

// File: tb/test_cplx_mul.sv
`timescale 1ns/1ps
module test_cplx_mul;
  localparam int IN_W = 16;
  localparam int OW   = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic signed [IN_W-1:0] xr = '0, xi = '0, yr = '0, yi = '0;

  logic v3, v4, vw;
  logic signed [OW-1:0] re3, im3, re4, im4, rew, imw;
  logic [7:0] lat3, lat4, latw;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;

  longint h_a [256], h_b [256], h_c [256], h_d [256];
  bit     h_v [256];

  always #2.5 clk = ~clk;

  // R2 R5 R6: three multipliers, grow, half-up, latency 2+2*1=4
  cplx_mul #(.FOUR_MUL(1'b0), .OVF(cm_pkg::OVF_GROW), .RND(cm_pkg::RND_HALF_UP),
             .MUL_PIPE(2), .ADD_PIPE(1)) i_cplx_mul (
    .clk_i(clk), .rst_ni, .valid_i, .xr_i(xr), .xi_i(xi), .yr_i(yr), .yi_i(yi),
    .valid_o(v3), .re_o(re3), .im_o(im3), .lat_o(lat3));

  // R1 R5: four multipliers, grow, floor, latency 1+2=3
  cplx_mul #(.FOUR_MUL(1'b1), .OVF(cm_pkg::OVF_GROW), .RND(cm_pkg::RND_FLOOR),
             .MUL_PIPE(1), .ADD_PIPE(2)) i_cplx_mul_four (
    .clk_i(clk), .rst_ni, .valid_i, .xr_i(xr), .xi_i(xi), .yr_i(yr), .yi_i(yi),
    .valid_o(v4), .re_o(re4), .im_o(im4), .lat_o(lat4));

  // R7: three multipliers, wrap, floor, latency 0
  cplx_mul #(.FOUR_MUL(1'b0), .OVF(cm_pkg::OVF_WRAP), .RND(cm_pkg::RND_FLOOR),
             .MUL_PIPE(0), .ADD_PIPE(0)) i_cplx_mul_wrap (
    .clk_i(clk), .rst_ni, .valid_i, .xr_i(xr), .xi_i(xi), .yr_i(yr), .yi_i(yi),
    .valid_o(vw), .re_o(rew), .im_o(imw), .lat_o(latw));

  function automatic longint wrapw(longint v, int w);
    longint t;
    t = v <<< (64 - w);
    return t >>> (64 - w);
  endfunction

  function automatic longint model(bit four, bit grow, bit rhu, bit want_im,
                                   longint a, longint b, longint c, longint d);
    longint re, im, s1, s2, s3, k1, k2, k3;
    if (four) begin
      re = a * c - b * d;
      im = a * d + b * c;
    end else begin
      s1 = a + b; s2 = d - c; s3 = c + d;
      if (!grow) begin
        s1 = wrapw(s1, IN_W); s2 = wrapw(s2, IN_W); s3 = wrapw(s3, IN_W);
      end
      k1 = c * s1; k2 = a * s2; k3 = b * s3;
      re = k1 - k3;
      im = k1 + k2;
    end
    if (!grow) begin
      re = wrapw(re, 2 * IN_W);
      im = wrapw(im, 2 * IN_W);
    end
    if (rhu) begin
      re = re + (64'sd1 <<< 13);
      im = im + (64'sd1 <<< 13);
    end
    return want_im ? (im >>> 14) : (re >>> 14);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  task automatic check_inst(string name, bit four, bit grow, bit rhu, int lat,
                            logic v, logic signed [OW-1:0] re, logic signed [OW-1:0] im);
    int k;
    k = (cyc - lat) & 255;
    chk({name, " R4 valid"}, longint'(v), longint'(h_v[k]));
    chk({name, " re"}, longint'(re), model(four, grow, rhu, 1'b0, h_a[k], h_b[k], h_c[k], h_d[k]));
    chk({name, " im"}, longint'(im), model(four, grow, rhu, 1'b1, h_a[k], h_b[k], h_c[k], h_d[k]));
  endtask

  function automatic logic signed [IN_W-1:0] pick(int unsigned r, bit corner);
    if (!corner) return IN_W'(r);
    case (r % 5)
      0: return -16'sd32768;
      1: return 16'sd32767;
      2: return 16'sd0;
      3: return 16'sd1;
      default: return -16'sd1;
    endcase
  endfunction

  task automatic drive_cycle(bit v, logic signed [IN_W-1:0] a, logic signed [IN_W-1:0] b,
                             logic signed [IN_W-1:0] c, logic signed [IN_W-1:0] d);
    @(posedge clk);
    #1;
    cyc++;
    valid_i = v; xr = a; xi = b; yr = c; yi = d;
    h_v[cyc & 255] = v;
    h_a[cyc & 255] = longint'(a); h_b[cyc & 255] = longint'(b);
    h_c[cyc & 255] = longint'(c); h_d[cyc & 255] = longint'(d);
    @(negedge clk);
    check_inst("three/grow/half-up R2 R5 R6", 1'b0, 1'b1, 1'b1, 4, v3, re3, im3);
    check_inst("four/grow/floor R1 R5", 1'b1, 1'b1, 1'b0, 3, v4, re4, im4);
    check_inst("three/wrap/floor R7 R8", 1'b0, 1'b0, 1'b0, 0, vw, rew, imw);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h00c0ffee);
    for (int i = 0; i < 256; i++) begin
      h_a[i] = 0; h_b[i] = 0; h_c[i] = 0; h_d[i] = 0; h_v[i] = 1'b0;
    end
    // reset state, R4
    repeat (3) @(negedge clk);
    chk("R4 reset valid three", longint'(v3), 0);
    chk("R4 reset valid four", longint'(v4), 0);
    chk("R4 reset re three", longint'(re3), 0);
    chk("R4 reset im four", longint'(im4), 0);
    // R3 latency constants
    chk("R3 lat three", longint'(lat3), 4);
    chk("R3 lat four", longint'(lat4), 3);
    chk("R3 lat wrap", longint'(latw), 0);
    @(posedge clk);
    #1 rst_ni = 1'b1;
    // R9 zero operands, R5 half-up carry: 0.5 LSB products
    drive_cycle(1'b1, 16'sd0, 16'sd0, 16'sd0, 16'sd0);
    drive_cycle(1'b1, 16'sd1, 16'sd0, 16'sd1, 16'sd0);
    drive_cycle(1'b1, 16'sd128, 16'sd0, 16'sd64, 16'sd0);
    drive_cycle(1'b1, -16'sd128, 16'sd0, 16'sd64, 16'sd0);
    // R6 R7 extremes: pre-adders overflow IN_W
    drive_cycle(1'b1, -16'sd32768, -16'sd32768, -16'sd32768, -16'sd32768);
    drive_cycle(1'b0, 16'sd32767, 16'sd32767, 16'sd32767, 16'sd32767);
    drive_cycle(1'b1, -16'sd32768, 16'sd32767, 16'sd32767, -16'sd32768);
    drive_cycle(1'b1, 16'sd5, 16'sd0, -16'sd32768, 16'sd0);
    // constrained random with corner mix; R8 data moves regardless of valid
    for (int n = 0; n < 600; n++) begin
      bit corner;
      corner = ($urandom % 4) == 0;
      drive_cycle(1'($urandom), pick($urandom, corner), pick($urandom, corner),
                  pick($urandom, corner), pick($urandom, corner));
    end
    // flush the pipelines
    for (int n = 0; n < 6; n++) drive_cycle(1'b0, 16'sd0, 16'sd0, 16'sd0, 16'sd0);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #200us;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule